// File: doc/BRIEF.md
# ADC Self-Calibration Sequencer

This block steers an internal calibration of an analog-to-digital converter. When it receives a start command, it first switches the converter input selector so that both inputs are tied to ground. It discards the first conversion, averages the next sixteen, and keeps that average as the offset coefficient, because the ideal code for a shorted input is zero. Unless the offset-only mode bit is set, it then connects the inputs to the reference lines, scaled by the programmed amplifier gain, and averages another sixteen conversions in the same way. From that second average it derives a normalized gain coefficient, using a restoring divider that takes several cycles.

A single finishing cycle presents both coefficients on a load port. In that cycle the block pulses `done_o` together with the load strobes and returns the input selector to normal operation. The correction datapath that consumes the coefficients, and the analog switching, are outside this block.

The controller has five states. IDLE waits for a start. OFS_RUN averages the shorted input. FS_RUN averages the scaled reference. DIVIDE runs the divider. FINISH issues the loads. The transitions are:
- IDLE→OFS_RUN on start.
- OFS_RUN→FS_RUN when the offset average is ready and the mode is full.
- OFS_RUN→FINISH when the offset average is ready and the mode is offset-only.
- FS_RUN→DIVIDE when the denominator is positive.
- FS_RUN→FINISH when the denominator is zero or negative.
- DIVIDE→FINISH when the quotient is ready.
- FINISH→IDLE unconditionally.

Top module: `adc_selfcal_seq`

## Requirements
- R1: After reset the outputs are as follows: `busy_o`, `done_o`, both load strobes and `fs_err_o` are 0; `mux_sel_o` is 2'b00 (normal) and `ref_scale_o` is 0; both coefficients are 0.
- R2: `start_i` is accepted only in IDLE, and `busy_o` is 1 from the next cycle until IDLE is re-entered. A `start_i` that arrives while busy has no effect on the sequence or on its results.
- R3: After every selector change, the first valid conversion is dropped. A conversion counts only while a phase is collecting. A conversion that coincides with the edge that enters a phase is ignored, and so is any conversion in the cycle after the sixteenth accepted sample.
- R4: A phase sums sixteen accepted signed 24-bit samples in a 28-bit accumulator and shifts the sum arithmetically right by 4, which rounds toward minus infinity. The offset coefficient is that average minus the ideal zero code (0), in two's complement.
- R5: The offset phase always comes first, with `mux_sel_o` = 2'b01 (inputs grounded). The full-scale phase follows with `mux_sel_o` = 2'b10 (reference lines). During the full-scale phase only, `ref_scale_o` carries the gain code latched at start; otherwise it is 0.
- R6: If `offset_only_i` is 1 when the start is accepted, the full-scale phase is skipped. FINISH then pulses `ofs_load_o` without `fs_load_o`, and `fs_coef_o` is unchanged.
- R7: The full-scale coefficient is floor(2^22 × 0x7FFFFF / (fs_avg − offset)), saturated to 0xFFFFFF. DIVIDE lasts NUM_W+1 = 47 cycles.
- R8: If fs_avg − offset ≤ 0, then `fs_coef_o` keeps its old value, `fs_load_o` stays 0 and `fs_err_o` is set. `fs_err_o` stays set until the next start is accepted, which clears it.
- R9: FINISH lasts exactly one cycle. In it, `done_o` and `ofs_load_o` are 1, `fs_load_o` is 1 only for a full run without error, `mux_sel_o` is 2'b00 and `busy_o` is 1. IDLE follows.
- R10: A phase ends one cycle after its sixteenth accepted conversion. That is when the controller leaves OFS_RUN or FS_RUN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Calibration start command |
| offset_only_i | input | 1 | 1 selects an offset-only run, latched at start |
| pga_gain_i | input | 3 | Amplifier gain code, latched at start |
| conv_valid_i | input | 1 | Conversion result valid |
| conv_data_i | input | 24 | Signed conversion result |
| mux_sel_o | output | 2 | Input selector: 00 normal, 01 grounded, 10 reference |
| ref_scale_o | output | 3 | Divisor code for the reference during full-scale phase |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ofs_load_o | output | 1 | Offset coefficient load strobe |
| ofs_coef_o | output | 24 | Signed offset coefficient |
| fs_load_o | output | 1 | Full-scale coefficient load strobe |
| fs_coef_o | output | 24 | Unsigned gain coefficient, 0x400000 equals unity |
| fs_err_o | output | 1 | Full-scale denominator was not positive |

## Verification
The assertions expect `conv_valid_i` to be a plain strobe whose data is meaningful only in the cycle it is high. They also expect `start_i` to be free to arrive at any time, including in the middle of a run, without breaking the one-cycle completion pulse. The stimulus drives inputs only at falling edges. It feeds exactly seventeen samples per phase, waits for the selector to show the reference code before it sends full-scale data, and pulses a stray start while the controller is busy. The data sets cover a zero denominator, a denominator of one that saturates the quotient, negative offsets whose sums are not multiples of sixteen, and both offset-only and full runs.

// File: rtl/adc_cal_pkg.sv
`timescale 1ns/1ps
package adc_cal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFS,
        ST_FS,
        ST_DIV,
        ST_FIN
    } cal_state_t;

    localparam logic [1:0] MUX_NORMAL = 2'b00;
    localparam logic [1:0] MUX_SHORT  = 2'b01;
    localparam logic [1:0] MUX_REF    = 2'b10;

endpackage

// File: rtl/cal_averager.sv
`timescale 1ns/1ps
module cal_averager #(
    parameter int DATA_W   = 24,
    parameter int AVG_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              done_o,
    output logic [DATA_W-1:0] avg_o
);
    localparam int ACC_W = DATA_W + AVG_LOG2;
    localparam int CNT_W = AVG_LOG2 + 1;
    localparam int NSAMP = 1 << AVG_LOG2;

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             skip_q;
    logic             active_q;
    logic             done_q;
    logic [DATA_W-1:0] avg_q;

    logic [ACC_W-1:0]        ext_w;
    logic [ACC_W-1:0]        sum_w;
    logic signed [ACC_W-1:0] sum_s;
    logic [ACC_W-1:0]        shr_w;

    always_comb begin
        ext_w = {{AVG_LOG2{data_i[DATA_W-1]}}, data_i};
        sum_w = acc_q + ext_w;
        sum_s = $signed(sum_w);
        shr_w = sum_s >>> AVG_LOG2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            skip_q   <= 1'b0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
            avg_q    <= '0;
        end else if (clr_i) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            skip_q   <= 1'b1;
            active_q <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (active_q && valid_i) begin
                if (skip_q) begin
                    skip_q <= 1'b0;
                end else begin
                    acc_q <= sum_w;
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == CNT_W'(NSAMP - 1)) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                        avg_q    <= shr_w[DATA_W-1:0];
                    end
                end
            end
        end
    end

    assign done_o = done_q;
    assign avg_o  = avg_q;

    // R4: the sample count never passes the phase length
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NSAMP));

    // R3: once a phase has its average, further samples are not collected
    p_stop_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr_i) |=> $stable(acc_q));

endmodule

// File: rtl/cal_divider.sv
`timescale 1ns/1ps
module cal_divider #(
    parameter int NUM_W = 46,
    parameter int DEN_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quot_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    logic [DEN_W:0] trial_w;
    logic [DEN_W:0] diff_w;
    logic           fits_w;

    always_comb begin
        trial_w = {rem_q, quo_q[NUM_W-1]};
        diff_w  = trial_w - {1'b0, den_q};
        fits_w  = (trial_w >= {1'b0, den_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (start_i) begin
            rem_q  <= '0;
            den_q  <= den_i;
            quo_q  <= num_i;
            cnt_q  <= CNT_W'(NUM_W);
            done_q <= 1'b0;
        end else if (cnt_q != '0) begin
            rem_q  <= fits_w ? diff_w[DEN_W-1:0] : trial_w[DEN_W-1:0];
            quo_q  <= {quo_q[NUM_W-2:0], fits_w};
            cnt_q  <= cnt_q - CNT_W'(1);
            done_q <= (cnt_q == CNT_W'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done_o = done_q;
    assign quot_o = quo_q;

    // R7: the partial remainder stays below the divisor while iterating
    p_rem_below_den_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (rem_q < den_q));

endmodule

// File: rtl/adc_selfcal_seq.sv
`timescale 1ns/1ps
module adc_selfcal_seq
    import adc_cal_pkg::*;
#(
    parameter int          DATA_W     = 24,
    parameter int          AVG_LOG2   = 4,
    parameter int          GAIN_W     = 3,
    parameter int          GAIN_SHIFT = 22,
    parameter int unsigned IDEAL_FS   = 32'h007F_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              offset_only_i,
    input  logic [GAIN_W-1:0] pga_gain_i,
    input  logic              conv_valid_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic [1:0]        mux_sel_o,
    output logic [GAIN_W-1:0] ref_scale_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              ofs_load_o,
    output logic [DATA_W-1:0] ofs_coef_o,
    output logic              fs_load_o,
    output logic [DATA_W-1:0] fs_coef_o,
    output logic              fs_err_o
);
    localparam int DEN_W = DATA_W + 1;
    localparam int NUM_W = DATA_W + GAIN_SHIFT;
    localparam logic [NUM_W-1:0] FS_NUM = NUM_W'(IDEAL_FS) << GAIN_SHIFT;

    cal_state_t state_q, state_d;

    logic              oo_q;
    logic [GAIN_W-1:0] gain_q;
    logic              err_q;
    logic [DATA_W-1:0] ofs_q;
    logic [DATA_W-1:0] fs_q;

    logic              avg_clr;
    logic              avg_done;
    logic [DATA_W-1:0] avg_w;
    logic [DEN_W-1:0]  den_w;
    logic              den_ok;
    logic              div_start;
    logic              div_done;
    logic [NUM_W-1:0]  quot_w;
    logic [DATA_W-1:0] quot_sat;

    always_comb begin
        den_w     = {avg_w[DATA_W-1], avg_w} - {ofs_q[DATA_W-1], ofs_q};
        den_ok    = !den_w[DEN_W-1] && (den_w != '0);
        avg_clr   = ((state_q == ST_IDLE) && start_i) ||
                    ((state_q == ST_OFS) && avg_done && !oo_q);
        div_start = (state_q == ST_FS) && avg_done && den_ok;
        quot_sat  = (quot_w[NUM_W-1:DATA_W] != '0) ? {DATA_W{1'b1}}
                                                   : quot_w[DATA_W-1:0];
    end

    cal_averager #(
        .DATA_W  (DATA_W),
        .AVG_LOG2(AVG_LOG2)
    ) avg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (avg_clr),
        .valid_i(conv_valid_i),
        .data_i (conv_data_i),
        .done_o (avg_done),
        .avg_o  (avg_w)
    );

    cal_divider #(
        .NUM_W(NUM_W),
        .DEN_W(DEN_W)
    ) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(div_start),
        .num_i  (FS_NUM),
        .den_i  (den_w),
        .done_o (div_done),
        .quot_o (quot_w)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_OFS;
            ST_OFS:  if (avg_done) state_d = oo_q ? ST_FIN : ST_FS;
            ST_FS:   if (avg_done) state_d = den_ok ? ST_DIV : ST_FIN;
            ST_DIV:  if (div_done) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state and per-run registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            oo_q    <= 1'b0;
            gain_q  <= '0;
            err_q   <= 1'b0;
            ofs_q   <= '0;
            fs_q    <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && start_i) begin
                oo_q   <= offset_only_i;
                gain_q <= pga_gain_i;
                err_q  <= 1'b0;
            end
            if ((state_q == ST_OFS) && avg_done) ofs_q <= avg_w;
            if ((state_q == ST_FS) && avg_done && !den_ok) err_q <= 1'b1;
            if ((state_q == ST_DIV) && div_done) fs_q <= quot_sat;
        end
    end

    // outputs decoded from state
    always_comb begin
        mux_sel_o   = MUX_NORMAL;
        ref_scale_o = '0;
        busy_o      = 1'b1;
        done_o      = 1'b0;
        ofs_load_o  = 1'b0;
        fs_load_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_OFS:  mux_sel_o = MUX_SHORT;
            ST_FS: begin
                mux_sel_o   = MUX_REF;
                ref_scale_o = gain_q;
            end
            ST_DIV: ;
            ST_FIN: begin
                done_o     = 1'b1;
                ofs_load_o = 1'b1;
                fs_load_o  = !oo_q && !err_q;
            end
            default: busy_o = 1'b0;
        endcase
    end

    assign ofs_coef_o = ofs_q;
    assign fs_coef_o  = fs_q;
    assign fs_err_o   = err_q;

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: a coefficient load is only seen together with done
    p_load_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fs_load_o |-> (done_o && ofs_load_o));

    // R2: a start while busy does not abort the run
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);

    // R5: a run always opens on the grounded input
    p_short_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (mux_sel_o == MUX_SHORT));

    // R5: the reference is never selected straight from normal operation
    p_ref_after_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel_o == MUX_REF) |-> ($past(mux_sel_o) != MUX_NORMAL));

    // R8: a failed full-scale phase leaves the gain coefficient alone
    p_err_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fs_err_o) |-> (!fs_load_o && $stable(fs_coef_o)));

endmodule

// File: tb/adc_selfcal_seq_tb.sv
`timescale 1ns/1ps
module adc_selfcal_seq_tb_top;
    localparam int    NUM_W  = 46;
    localparam longint FSNUM = longint'(32'h007F_FFFF) << 22;
    localparam longint QMAX  = 64'h0000_0000_00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        oo = 1'b0;
    logic [2:0]  gain = '0;
    logic        cvalid = 1'b0;
    logic [23:0] cdata = '0;
    logic [1:0]  mux_sel_o;
    logic [2:0]  ref_scale_o;
    logic        busy_o, done_o, ofs_load_o, fs_load_o, fs_err_o;
    logic [23:0] ofs_coef_o, fs_coef_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic signed [23:0] ov [17];
    logic signed [23:0] fv [17];

    always #2.5 clk = ~clk;

    adc_selfcal_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .offset_only_i(oo),
        .pga_gain_i(gain), .conv_valid_i(cvalid), .conv_data_i(cdata),
        .mux_sel_o(mux_sel_o), .ref_scale_o(ref_scale_o), .busy_o(busy_o),
        .done_o(done_o), .ofs_load_o(ofs_load_o), .ofs_coef_o(ofs_coef_o),
        .fs_load_o(fs_load_o), .fs_coef_o(fs_coef_o), .fs_err_o(fs_err_o)
    );

    task automatic cmp(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int     m_st = 0;
    bit     m_oo, m_err, m_disc, m_wait;
    int     m_cnt, m_dc;
    logic [2:0] m_gain;
    longint m_acc, m_ofs, m_fs, m_fs_new;

    always @(posedge clk) begin
        longint avg, den, q;
        if (!rst_n) begin
            m_st = 0; m_oo = 0; m_err = 0; m_disc = 0; m_wait = 0;
            m_cnt = 0; m_dc = 0; m_gain = '0; m_acc = 0; m_ofs = 0;
            m_fs = 0; m_fs_new = 0;
        end else begin
            case (m_st)
                0: if (start) begin
                    m_st = 1; m_gain = gain; m_oo = oo; m_err = 0;
                    m_cnt = 0; m_disc = 1; m_wait = 0; m_acc = 0;
                end
                1, 2: begin
                    if (m_wait) begin
                        m_wait = 0;
                        avg = m_acc >>> 4;
                        if (m_st == 1) begin
                            m_ofs = avg;
                            if (m_oo) m_st = 4;
                            else begin
                                m_st = 2; m_cnt = 0; m_disc = 1; m_acc = 0;
                            end
                        end else begin
                            den = avg - m_ofs;
                            if (den <= 0) begin
                                m_err = 1; m_st = 4;
                            end else begin
                                q = FSNUM / den;
                                m_fs_new = (q > QMAX) ? QMAX : q;
                                m_st = 3; m_dc = 0;
                            end
                        end
                    end else if (cvalid) begin
                        if (m_disc) m_disc = 0;
                        else begin
                            m_acc = m_acc + longint'($signed(cdata));
                            m_cnt++;
                            if (m_cnt == 16) m_wait = 1;
                        end
                    end
                end
                3: begin
                    m_dc++;
                    if (m_dc == NUM_W + 1) begin
                        m_fs = m_fs_new; m_st = 4;
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cmp("R2 busy", busy_o, m_st != 0);
            cmp("R5 mux", mux_sel_o, (m_st == 1) ? 1 : (m_st == 2) ? 2 : 0);
            cmp("R5 ref_scale", ref_scale_o, (m_st == 2) ? m_gain : 0);
            cmp("R10 done", done_o, m_st == 4);
            cmp("R9 ofs_load", ofs_load_o, m_st == 4);
            cmp("R6 fs_load", fs_load_o, (m_st == 4) && !m_oo && !m_err);
            cmp("R8 fs_err", fs_err_o, m_err);
            cmp("R4 ofs_coef", longint'($signed(ofs_coef_o)), m_ofs);
            cmp("R7 fs_coef", longint'(fs_coef_o), m_fs);
        end
    end

    task automatic feed(input bit use_fs, input int gap, input bit poke);
        for (int i = 0; i < 17; i++) begin
            cvalid = 1'b1;
            cdata  = use_fs ? fv[i] : ov[i];
            start  = poke && (i == 5);
            @(negedge clk);
            cvalid = 1'b0;
            start  = 1'b0;
            for (int k = 0; k < gap; k++) @(negedge clk);
        end
    endtask

    task automatic run_cal(input bit mode_oo, input logic [2:0] g,
                           input int gap, input bit poke);
        longint s;
        @(negedge clk);
        start = 1'b1; oo = mode_oo; gain = g;
        @(negedge clk);
        start = 1'b0;
        feed(1'b0, gap, poke);
        if (!mode_oo) begin
            while (mux_sel_o !== 2'b10) @(negedge clk);
            feed(1'b1, gap, 1'b0);
        end
        while (done_o !== 1'b1) @(negedge clk);
        s = 0;
        for (int i = 1; i < 17; i++) s += longint'(ov[i]);
        // R3: the first sample of the phase must not be in the average
        cmp("R3 offset excludes first sample", longint'($signed(ofs_coef_o)), s >>> 4);
        @(negedge clk);
        oo = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        cmp("R1 busy", busy_o, 0);
        cmp("R1 done", done_o, 0);
        cmp("R1 mux", mux_sel_o, 0);
        cmp("R1 coefs", longint'(ofs_coef_o) + longint'(fs_coef_o), 0);
        cmp("R1 err", fs_err_o, 0);

        // full run, small positive offset
        for (int i = 0; i < 17; i++) begin
            ov[i] = 24'(90 + 3 * i);
            fv[i] = 24'(32'h7E0000 + 7 * i);
        end
        ov[0] = 24'h7FFFFF;
        run_cal(1'b0, 3'd0, 0, 1'b0);

        // negative offset, uneven sum, stray start while busy (R2)
        for (int i = 0; i < 17; i++) begin
            ov[i] = -24'(37 + 5 * i);
            fv[i] = 24'(32'h3F0000 - 11 * i);
        end
        run_cal(1'b0, 3'd3, 2, 1'b1);

        // R6: offset-only mode leaves full-scale coefficient intact
        for (int i = 0; i < 17; i++) ov[i] = 24'(i * 13 - 100);
        run_cal(1'b1, 3'd5, 1, 1'b0);

        // R8: zero denominator
        for (int i = 0; i < 17; i++) begin
            ov[i] = 24'(500);
            fv[i] = 24'(500);
        end
        run_cal(1'b0, 3'd2, 0, 1'b0);
        cmp("R8 error flag held in idle", fs_err_o, 1);

        // R7: denominator of one saturates
        for (int i = 0; i < 17; i++) begin
            ov[i] = 24'(0);
            fv[i] = 24'(1);
        end
        run_cal(1'b0, 3'd1, 0, 1'b0);
        cmp("R7 saturated coefficient", fs_coef_o, QMAX);

        // recovery with gain code 7, error cleared (R8)
        for (int i = 0; i < 17; i++) begin
            ov[i] = -24'(3 * i);
            fv[i] = 24'(32'h7FFF00 - i);
        end
        run_cal(1'b0, 3'd7, 1, 1'b0);
        cmp("R8 error cleared by new start", fs_err_o, 0);

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule